// File: doc/BRIEF.md
# Sweep-Synchronised Event Timestamper

This block tags the timing events of a swept-source imaging front end against one shared time base. A free-running counter on the sample clock provides the timestamp, so its resolution is one converter clock period. Five asynchronous inputs enter the block: sweep start, wavenumber clock marker, line sync, frame sync and an external trigger. The block keeps a running frame index, line index, sweep index and a count of wavenumber markers seen since the last sweep start. Reconstruction logic downstream can then place any sample on its sweep, scan line and frame.

Each sweep start, line sync, frame sync or external trigger produces one record: the event kind, the timestamp, the three indices and the marker count. The record leaves through a valid/ready port. The output holds one record. If that record is still unaccepted when another event arrives, the new event is lost and a sticky flag is raised. A sweep start also arms a programmable delay. When the delay ends, the block drives a trigger output pulse whose width is programmable.

Top module: `sweep_event_stamper`

## Requirements
- R1: Every asynchronous input passes through a two-stage synchroniser, and only its rising edge counts as an event. An input held high for many cycles yields exactly one event.
- R2: The timestamp counter is zero after reset and advances by one each clock. It is TS_W bits wide and wraps modulo 2^TS_W. The timestamps of two records differ by exactly the number of clocks between the rising edges of their inputs.
- R3: A sweep-start edge increments the sweep index and clears the marker count to 0. Its record has kind 0 and carries the new sweep index and a marker count of 0.
- R4: Each rising edge of the wavenumber marker input increments the marker count. Marker edges never produce a record. A marker edge in the same cycle as a sweep-start edge is not counted.
- R5: A line-sync edge increments the line index and clears the sweep index to 0, and this clear overrides a coincident sweep increment. Its record has kind 1.
- R6: A frame-sync edge increments the frame index and clears the line index to 0, and this clear overrides a coincident line increment. A frame-sync edge leaves the sweep index alone. Its record has kind 2.
- R7: An external-trigger edge changes no index. Its record has kind 3 and carries the indices as they stand.
- R8: When several record-producing edges fall in one cycle, only one record is emitted, chosen in the priority order frame (2), line (1), sweep (0), external (3). The index updates of all of those edges are still applied. Every record shows the indices after that cycle's updates.
- R9: While rec_valid is high and rec_ready is low, every record field stays unchanged.
- R10: An event that arrives while rec_valid is high and rec_ready is low is dropped. The stored record is kept, and ovf is set and stays set until reset. Index tracking continues regardless.
- R11: trig_out rises D cycles after the sweep record becomes valid, where D is trig_dly sampled at the sweep edge and a D of 0 acts as 1. It stays high for trig_len cycles, and a trig_len of 0 gives no pulse.
- R12: A new sweep-start edge during the delay or during the pulse forces trig_out low and restarts the delay using the newly sampled settings.
- R13: After reset, rec_valid, ovf and trig_out are 0, and all indices and the marker count start from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, also the timestamp time base |
| rst_n | input | 1 | Synchronous active-low reset |
| sweep_trig_a | input | 1 | Asynchronous sweep-start trigger |
| kclk_a | input | 1 | Asynchronous wavenumber clock marker |
| line_sync_a | input | 1 | Asynchronous line sync |
| frame_sync_a | input | 1 | Asynchronous frame sync |
| ext_trig_a | input | 1 | Asynchronous external trigger |
| trig_dly | input | DLY_W | Trigger output delay in clocks, sampled at each sweep edge |
| trig_len | input | DLY_W | Trigger output pulse width in clocks, sampled at each sweep edge |
| trig_out | output | 1 | Delayed trigger pulse |
| rec_valid | output | 1 | A record is on the output |
| rec_ready | input | 1 | The consumer accepts the record |
| rec_kind | output | 2 | 0 sweep, 1 line, 2 frame, 3 external |
| rec_time | output | TS_W | Timestamp of the event |
| rec_sweep | output | SW_W | Sweep index within the line |
| rec_line | output | LN_W | Line index within the frame |
| rec_frame | output | FR_W | Frame index |
| rec_kcount | output | KC_W | Marker count within the sweep |
| ovf | output | 1 | Sticky flag: an event was dropped |

## Verification
Some properties are checked on every cycle by assertions. Each synchronised edge lasts exactly one cycle. The timestamp steps by one. A sweep edge clears the marker count, a line edge clears the sweep index, and a frame edge clears the line index. A stalled record stays frozen, and the overflow flag never falls. A trigger pulse never starts with a zero width, and a new sweep edge always pulls the trigger low.

Other behaviours can only be shown by the bench's scenarios:
- the index values and record kinds over a long event sequence;
- which record wins when edges coincide;
- the exact timestamp spacing between records;
- the measured trigger delay and width, including a restart;
- that tracking continues past a dropped event.

// File: rtl/ses_pkg.sv
// Shared definitions for the sweep event timestamper.
// Assumes the five event sources are ordered as the SRC_* indices below.
package ses_pkg;
    localparam int N_SRC     = 5;
    localparam int SRC_SWEEP = 0;
    localparam int SRC_KCLK  = 1;
    localparam int SRC_LINE  = 2;
    localparam int SRC_FRAME = 3;
    localparam int SRC_EXT   = 4;

    typedef enum logic [1:0] {
        EV_SWEEP = 2'd0,
        EV_LINE  = 2'd1,
        EV_FRAME = 2'd2,
        EV_EXT   = 2'd3
    } ev_kind_t;

    typedef enum logic [1:0] {
        TD_IDLE = 2'd0,
        TD_WAIT = 2'd1,
        TD_HIGH = 2'd2
    } td_state_t;
endpackage

// File: rtl/ses_sync_edge.sv
// Synchroniser plus rising-edge detector for one asynchronous input.
// Assumes the input stays high or low for at least two clocks per level;
// the rise output is a single-cycle pulse at a fixed latency.
module ses_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] shift_q;
    logic              last_q;

    // Move the input through the synchroniser chain and remember the last stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            last_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign rise = shift_q[STAGES-1] & ~last_q;

    // R1: an edge never lasts two cycles
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ses_index_track.sv
// Keeps the time base, the sweep, line and frame indices and the marker
// count. Its outputs are the values after this cycle's events, so that a
// record captured in this cycle shows the updated indices.
// Assumes event inputs are single-cycle synchronised pulses.
module ses_index_track #(
    parameter int TS_W = 48,
    parameter int SW_W = 16,
    parameter int LN_W = 16,
    parameter int FR_W = 16,
    parameter int KC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_sweep,
    input  logic            ev_kclk,
    input  logic            ev_line,
    input  logic            ev_frame,
    output logic [TS_W-1:0] ts,
    output logic [SW_W-1:0] nxt_sweep,
    output logic [LN_W-1:0] nxt_line,
    output logic [FR_W-1:0] nxt_frame,
    output logic [KC_W-1:0] nxt_kc
);
    logic [TS_W-1:0] ts_q;
    logic [SW_W-1:0] sweep_q;
    logic [LN_W-1:0] line_q;
    logic [FR_W-1:0] frame_q;
    logic [KC_W-1:0] kc_q;

    // Work out the index values after this cycle's events, clears winning over increments.
    always_comb begin
        nxt_kc    = kc_q;
        nxt_sweep = sweep_q;
        nxt_line  = line_q;
        nxt_frame = frame_q;
        if (ev_sweep)      nxt_kc = '0;
        else if (ev_kclk)  nxt_kc = kc_q + 1'b1;
        if (ev_line)       nxt_sweep = '0;
        else if (ev_sweep) nxt_sweep = sweep_q + 1'b1;
        if (ev_frame)      nxt_line = '0;
        else if (ev_line)  nxt_line = line_q + 1'b1;
        if (ev_frame)      nxt_frame = frame_q + 1'b1;
    end

    // Advance the time base and register the updated indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q    <= '0;
            sweep_q <= '0;
            line_q  <= '0;
            frame_q <= '0;
            kc_q    <= '0;
        end else begin
            ts_q    <= ts_q + 1'b1;
            sweep_q <= nxt_sweep;
            line_q  <= nxt_line;
            frame_q <= nxt_frame;
            kc_q    <= nxt_kc;
        end
    end

    assign ts = ts_q;

    // R2: the time base moves by exactly one per clock, wrapping
    a_r2_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ts_q == TS_W'($past(ts_q) + 1'b1));
    // R3: a sweep start leaves the marker count at zero
    a_r3_kc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sweep |=> kc_q == '0);
    // R5: a line sync leaves the sweep index at zero
    a_r5_sweep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ev_line |=> sweep_q == '0);
    // R6: a frame sync leaves the line index at zero
    a_r6_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame |=> line_q == '0);
endmodule

// File: rtl/ses_trig_delay.sv
// Delayed trigger pulse generator. A reference edge samples the delay and
// width settings and starts the delay; a new edge restarts it at any time.
// A delay of 0 behaves as 1; a width of 0 gives no pulse.
module ses_trig_delay #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_ev,
    input  logic [DLY_W-1:0] dly_cfg,
    input  logic [DLY_W-1:0] len_cfg,
    output logic             trig_out
);
    import ses_pkg::*;

    td_state_t        st_q;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] len_q;

    // Step through wait and pulse phases, restarting on each reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TD_IDLE;
            cnt_q <= '0;
            len_q <= '0;
        end else if (ref_ev) begin
            st_q  <= TD_WAIT;
            cnt_q <= dly_cfg;
            len_q <= len_cfg;
        end else begin
            case (st_q)
                TD_WAIT: begin
                    if (cnt_q <= DLY_W'(1)) begin
                        if (len_q == '0) begin
                            st_q <= TD_IDLE;
                        end else begin
                            st_q  <= TD_HIGH;
                            cnt_q <= len_q;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                TD_HIGH: begin
                    if (cnt_q <= DLY_W'(1)) st_q <= TD_IDLE;
                    else                    cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= TD_IDLE;
            endcase
        end
    end

    assign trig_out = (st_q == TD_HIGH);

    // R11: a pulse only ever starts with a non-zero width latched
    a_r11_no_zero_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> len_q != '0);
    // R12: a new reference edge always drops the output
    a_r12_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ev |=> !trig_out);
endmodule

// File: rtl/ses_record_out.sv
// Builds one record per cycle from the prioritised events and holds it in a
// single output register under valid/ready. An event that finds the
// register full and not being taken is dropped, and a sticky flag is set.
module ses_record_out #(
    parameter int TS_W = 48,
    parameter int SW_W = 16,
    parameter int LN_W = 16,
    parameter int FR_W = 16,
    parameter int KC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_sweep,
    input  logic            ev_line,
    input  logic            ev_frame,
    input  logic            ev_ext,
    input  logic [TS_W-1:0] ts,
    input  logic [SW_W-1:0] nxt_sweep,
    input  logic [LN_W-1:0] nxt_line,
    input  logic [FR_W-1:0] nxt_frame,
    input  logic [KC_W-1:0] nxt_kc,
    input  logic            rec_ready,
    output logic            rec_valid,
    output logic [1:0]      rec_kind,
    output logic [TS_W-1:0] rec_time,
    output logic [SW_W-1:0] rec_sweep,
    output logic [LN_W-1:0] rec_line,
    output logic [FR_W-1:0] rec_frame,
    output logic [KC_W-1:0] rec_kcount,
    output logic            ovf
);
    import ses_pkg::*;

    ev_kind_t kind_sel;
    logic     any_ev;
    logic     slot_free;

    // Pick the record kind by priority: frame, line, sweep, external.
    always_comb begin
        if (ev_frame)      kind_sel = EV_FRAME;
        else if (ev_line)  kind_sel = EV_LINE;
        else if (ev_sweep) kind_sel = EV_SWEEP;
        else               kind_sel = EV_EXT;
    end

    assign any_ev    = ev_sweep | ev_line | ev_frame | ev_ext;
    assign slot_free = !rec_valid || rec_ready;

    // Load a new record when the slot frees up, drop and flag otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid  <= 1'b0;
            rec_kind   <= 2'd0;
            rec_time   <= '0;
            rec_sweep  <= '0;
            rec_line   <= '0;
            rec_frame  <= '0;
            rec_kcount <= '0;
            ovf        <= 1'b0;
        end else begin
            if (any_ev && slot_free) begin
                rec_valid  <= 1'b1;
                rec_kind   <= kind_sel;
                rec_time   <= ts;
                rec_sweep  <= nxt_sweep;
                rec_line   <= nxt_line;
                rec_frame  <= nxt_frame;
                rec_kcount <= nxt_kc;
            end else if (rec_ready) begin
                rec_valid <= 1'b0;
            end
            if (any_ev && !slot_free) ovf <= 1'b1;
        end
    end

    // R9: a stalled record is frozen
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> rec_valid && $stable(rec_time) && $stable(rec_kind)
            && $stable(rec_sweep) && $stable(rec_kcount));
    // R10: the drop flag never falls outside reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
endmodule

// File: rtl/sweep_event_stamper.sv
// Top level: synchronises the five trigger inputs and tracks indices.
// Emits timestamped event records and drives the delayed trigger output.
// Assumes every input level lasts at least two clocks.
module sweep_event_stamper #(
    parameter int TS_W        = 48,
    parameter int SW_W        = 16,
    parameter int LN_W        = 16,
    parameter int FR_W        = 16,
    parameter int KC_W        = 16,
    parameter int DLY_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sweep_trig_a,
    input  logic             kclk_a,
    input  logic             line_sync_a,
    input  logic             frame_sync_a,
    input  logic             ext_trig_a,
    input  logic [DLY_W-1:0] trig_dly,
    input  logic [DLY_W-1:0] trig_len,
    output logic             trig_out,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [1:0]       rec_kind,
    output logic [TS_W-1:0]  rec_time,
    output logic [SW_W-1:0]  rec_sweep,
    output logic [LN_W-1:0]  rec_line,
    output logic [FR_W-1:0]  rec_frame,
    output logic [KC_W-1:0]  rec_kcount,
    output logic             ovf
);
    import ses_pkg::*;

    logic [N_SRC-1:0] raw_in;
    logic [N_SRC-1:0] ev;
    logic [TS_W-1:0]  ts;
    logic [SW_W-1:0]  nxt_sweep;
    logic [LN_W-1:0]  nxt_line;
    logic [FR_W-1:0]  nxt_frame;
    logic [KC_W-1:0]  nxt_kc;

    always_comb begin
        raw_in            = '0;
        raw_in[SRC_SWEEP] = sweep_trig_a;
        raw_in[SRC_KCLK]  = kclk_a;
        raw_in[SRC_LINE]  = line_sync_a;
        raw_in[SRC_FRAME] = frame_sync_a;
        raw_in[SRC_EXT]   = ext_trig_a;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_sync
        ses_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (ev[g])
        );
    end

    ses_index_track #(
        .TS_W(TS_W), .SW_W(SW_W), .LN_W(LN_W), .FR_W(FR_W), .KC_W(KC_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_sweep (ev[SRC_SWEEP]),
        .ev_kclk  (ev[SRC_KCLK]),
        .ev_line  (ev[SRC_LINE]),
        .ev_frame (ev[SRC_FRAME]),
        .ts       (ts),
        .nxt_sweep(nxt_sweep),
        .nxt_line (nxt_line),
        .nxt_frame(nxt_frame),
        .nxt_kc   (nxt_kc)
    );

    ses_record_out #(
        .TS_W(TS_W), .SW_W(SW_W), .LN_W(LN_W), .FR_W(FR_W), .KC_W(KC_W)
    ) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_sweep  (ev[SRC_SWEEP]),
        .ev_line   (ev[SRC_LINE]),
        .ev_frame  (ev[SRC_FRAME]),
        .ev_ext    (ev[SRC_EXT]),
        .ts        (ts),
        .nxt_sweep (nxt_sweep),
        .nxt_line  (nxt_line),
        .nxt_frame (nxt_frame),
        .nxt_kc    (nxt_kc),
        .rec_ready (rec_ready),
        .rec_valid (rec_valid),
        .rec_kind  (rec_kind),
        .rec_time  (rec_time),
        .rec_sweep (rec_sweep),
        .rec_line  (rec_line),
        .rec_frame (rec_frame),
        .rec_kcount(rec_kcount),
        .ovf       (ovf)
    );

    ses_trig_delay #(.DLY_W(DLY_W)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_ev  (ev[SRC_SWEEP]),
        .dly_cfg (trig_dly),
        .len_cfg (trig_len),
        .trig_out(trig_out)
    );
endmodule

// File: tb/tb_sweep_event_stamper.sv
`timescale 1ns/1ps
module tb_sweep_event_stamper;
    localparam int TS_W = 48;
    localparam int DLY_W = 16;

    // input mask bits: 0 sweep, 1 marker, 2 line, 3 frame, 4 external
    typedef struct packed {
        logic [4:0]  mask;
        logic        has_rec;
        logic [1:0]  kind;
        logic [15:0] sw;
        logic [15:0] ln;
        logic [15:0] fr;
        logic [15:0] kc;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{5'b00001, 1'b1, 2'd0, 16'd1, 16'd0, 16'd0, 16'd0},
        '{5'b00010, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{5'b00010, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{5'b10000, 1'b1, 2'd3, 16'd1, 16'd0, 16'd0, 16'd2},
        '{5'b00010, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{5'b00001, 1'b1, 2'd0, 16'd2, 16'd0, 16'd0, 16'd0},
        '{5'b00010, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{5'b00100, 1'b1, 2'd1, 16'd0, 16'd1, 16'd0, 16'd1},
        '{5'b00001, 1'b1, 2'd0, 16'd1, 16'd1, 16'd0, 16'd0},
        '{5'b01000, 1'b1, 2'd2, 16'd1, 16'd0, 16'd1, 16'd0},
        '{5'b00010, 1'b0, 2'd0, 16'd0, 16'd0, 16'd0, 16'd0},
        '{5'b00101, 1'b1, 2'd1, 16'd0, 16'd1, 16'd1, 16'd0},
        '{5'b11100, 1'b1, 2'd2, 16'd0, 16'd0, 16'd2, 16'd0},
        '{5'b00011, 1'b1, 2'd0, 16'd1, 16'd0, 16'd2, 16'd0},
        '{5'b10001, 1'b1, 2'd0, 16'd2, 16'd0, 16'd2, 16'd0},
        '{5'b10000, 1'b1, 2'd3, 16'd2, 16'd0, 16'd2, 16'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       ins = '0;
    logic [DLY_W-1:0] trig_dly = 16'd5;
    logic [DLY_W-1:0] trig_len = 16'd2;
    logic             trig_out, rec_valid, ovf;
    logic             rec_ready = 1'b0;
    logic [1:0]       rec_kind;
    logic [TS_W-1:0]  rec_time;
    logic [15:0]      rec_sweep, rec_line, rec_frame, rec_kcount;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sweep_event_stamper dut (
        .clk(clk), .rst_n(rst_n),
        .sweep_trig_a(ins[0]), .kclk_a(ins[1]), .line_sync_a(ins[2]),
        .frame_sync_a(ins[3]), .ext_trig_a(ins[4]),
        .trig_dly(trig_dly), .trig_len(trig_len), .trig_out(trig_out),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_kind(rec_kind),
        .rec_time(rec_time), .rec_sweep(rec_sweep), .rec_line(rec_line),
        .rec_frame(rec_frame), .rec_kcount(rec_kcount), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [4:0] m);
        @(negedge clk) ins = m;
        repeat (3) @(negedge clk);
        ins = '0;
    endtask

    task automatic wait_rec(output bit got);
        got = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (rec_valid) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic accept();
        rec_ready = 1'b1;
        @(negedge clk);
        rec_ready = 1'b0;
    endtask

    function automatic string tag_of(input logic [4:0] m, input logic [1:0] k);
        if ($countones(m & 5'b11101) > 1) return "R8";
        case (k)
            2'd0:    return "R3";
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // Runs 40 cycles with ready high, a sweep at cycle 0 and optionally a second one.
    task automatic measure(input int second_at, output int last_valid, output int last_rise,
                           output int n_rise, output int width);
        logic prev = 1'b0;
        last_valid = -1; last_rise = -1; n_rise = 0; width = 0;
        rec_ready = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 0 || i == second_at) ins = 5'b00001;
            if (i == 3 || i == second_at + 3) ins = '0;
            if (rec_valid) last_valid = i;
            if (trig_out && !prev) begin
                last_rise = i;
                n_rise++;
            end
            if (trig_out) width++;
            prev = trig_out;
        end
        rec_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit got;
        logic [TS_W-1:0] ts1, ts2;
        logic [15:0] sw_a;
        int t0, lv, lr, nr, wd, cnt;

        repeat (4) @(negedge clk);
        // R13: reset state
        check(rec_valid == 1'b0, "R13 rec_valid", 64'(rec_valid), 64'd0);
        check(ovf == 1'b0, "R13 ovf", 64'(ovf), 64'd0);
        check(trig_out == 1'b0, "R13 trig_out", 64'(trig_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R3 to R8 and R4 (marker edges give no record)
        for (int i = 0; i < 16; i++) begin
            pulse(VEC[i].mask);
            wait_rec(got);
            if (VEC[i].has_rec) begin
                check(got && rec_kind == VEC[i].kind && rec_sweep == VEC[i].sw &&
                      rec_line == VEC[i].ln && rec_frame == VEC[i].fr && rec_kcount == VEC[i].kc,
                      tag_of(VEC[i].mask, VEC[i].kind),
                      {got, 5'd0, rec_kind, rec_sweep[7:0], rec_line[7:0], rec_frame[7:0], rec_kcount[7:0]},
                      {1'b1, 5'd0, VEC[i].kind, VEC[i].sw[7:0], VEC[i].ln[7:0], VEC[i].fr[7:0], VEC[i].kc[7:0]});
                accept();
            end else begin
                check(!got, "R4 marker makes no record", 64'(got), 64'd0);
            end
        end
        check(ovf == 1'b0, "R10 no drop while draining", 64'(ovf), 64'd0);

        // R1: a long-held level gives one record
        rec_ready = 1'b1;
        cnt = 0;
        @(negedge clk) ins = 5'b10000;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rec_valid) cnt++;
        end
        ins = '0;
        repeat (6) @(negedge clk);
        rec_ready = 1'b0;
        check(cnt == 1, "R1 one event per rising edge", 64'(cnt), 64'd1);

        // R2: timestamp spacing equals edge spacing
        @(negedge clk) ins = 5'b10000;
        t0 = cyc;
        repeat (3) @(negedge clk);
        ins = '0;
        wait_rec(got);
        ts1 = rec_time;
        accept();
        while (cyc < t0 + 37) @(negedge clk);
        ins = 5'b10000;
        repeat (3) @(negedge clk);
        ins = '0;
        wait_rec(got);
        ts2 = rec_time;
        accept();
        check(got && (ts2 - ts1) == 37, "R2 timestamp spacing", 64'(ts2 - ts1), 64'd37);

        // R11: delay and width
        trig_dly = 16'd4; trig_len = 16'd3;
        measure(-1, lv, lr, nr, wd);
        check(lr - lv == 4, "R11 delay 4", 64'(lr - lv), 64'd4);
        check(wd == 3, "R11 width 3", 64'(wd), 64'd3);
        trig_dly = 16'd0; trig_len = 16'd2;
        measure(-1, lv, lr, nr, wd);
        check(lr - lv == 1, "R11 zero delay acts as one", 64'(lr - lv), 64'd1);
        check(wd == 2, "R11 width 2", 64'(wd), 64'd2);
        trig_dly = 16'd6; trig_len = 16'd0;
        measure(-1, lv, lr, nr, wd);
        check(wd == 0, "R11 zero width no pulse", 64'(wd), 64'd0);

        // R12: restart during delay, then during the pulse
        trig_dly = 16'd10; trig_len = 16'd3;
        measure(6, lv, lr, nr, wd);
        check(nr == 1 && lr - lv == 10, "R12 restart in delay", 64'(lr - lv), 64'd10);
        check(wd == 3, "R12 single pulse after restart", 64'(wd), 64'd3);
        trig_dly = 16'd2; trig_len = 16'd8;
        measure(8, lv, lr, nr, wd);
        check(nr == 2 && lr - lv == 2, "R12 restart in pulse", {32'(nr), 32'(lr - lv)}, {32'd2, 32'd2});

        // R10 and R9: stalled output drops the next event and freezes
        repeat (4) @(negedge clk);
        pulse(5'b10000);
        wait_rec(got);
        ts1 = rec_time;
        sw_a = rec_sweep;
        pulse(5'b00001);
        repeat (6) @(negedge clk);
        check(ovf == 1'b1, "R10 overflow flag set", 64'(ovf), 64'd1);
        check(rec_valid && rec_kind == 2'd3 && rec_time == ts1, "R9 record frozen while stalled",
              64'(rec_time), 64'(ts1));
        accept();
        repeat (3) @(negedge clk);
        check(ovf == 1'b1, "R10 overflow sticky", 64'(ovf), 64'd1);
        pulse(5'b10000);
        wait_rec(got);
        check(got && rec_sweep == sw_a + 16'd1, "R10 tracking continues past drop",
              64'(rec_sweep), 64'(sw_a + 16'd1));
        accept();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule